// File: doc/BRIEF.md
# Prioritised IRQ/FIQ Interrupt Controller

The controller gathers a parameterised number of 32-line banks of level-sensitive interrupt requests, plus software-forced requests, and drives two processor interrupt outputs: a normal one (IRQ) and a fast one (FIQ). Each line has a mask bit, a 6-bit priority and a steering bit that sends it to one of the two outputs. For each output, the controller picks one winning line among the active, unmasked lines steered to that output. It then latches the winner's number in a sorted-interrupt register and raises the output.

After raising an output, the controller stops arbitrating for that output. Software reads the winner, services it and writes a new-agreement command to re-arm that output. All access goes through a plain 32-bit register bus with address, write enable, write data and combinational read data. A global mask holds both outputs off without disturbing the per-line state. The configuration bits for auto-idle and idle are only stored.

Top module: `prio_intc`

## Requirements
- R1: After reset, both outputs are low. Every bank mask (bank register +0x04) reads 0xFFFFFFFF. Both winner registers (0x40 IRQ, 0x44 FIQ) read 0. Control (0x48) reads 0. Every line register reads 0.
- R2: The revision register (0x00) always reads 0x21 and status (0x14) always reads 1. The protection register (0x4C) reads 0, and writes to it or to any read-only register have no effect. Reads of unmapped addresses read 0, and so do reads of a bank at or above the bank count.
- R3: Bank register +0x00 (banks at 0x80 + 0x20×bank) shows the input levels one clock after they are applied. A rising level makes the line active. When a level falls, the line stays active only if its software bit is set.
- R4: Mask register +0x04 is written whole. Writing 1s to +0x08 clears those mask bits, and writing 1s to +0x0C sets them. Both +0x08 and +0x0C read 0.
- R5: A write to +0x10 ORs its value into the software bits (read back at +0x10) and into the active state. A write to +0x14 removes bits from the software set. The bank's active state then becomes the remaining software bits AND the input levels. +0x14 reads 0.
- R6: +0x18 reads active AND NOT mask AND NOT steering, and +0x1C reads active AND NOT mask AND steering.
- R7: The line register for global line n is at 0x100 + 4n. Writing it stores bits [7:2] as the priority and bit 0 as the steering bit (1 = FIQ). It reads back priority in [7:2], 0 in bit 1 and steering in bit 0.
- R8: An output goes high on the clock after a cycle in which three things hold: its agreement flag is armed, some line steered to it is pending, and the global mask is clear. On that edge the winner is latched and the flag is disarmed.
- R9: The winner is the pending line with the numerically lowest priority. Among lines of equal priority, the highest global line number (32×bank + bit) wins.
- R10: Once high, an output and its latched winner hold until that output is re-armed or soft reset. This holds even if lines are masked or drop, or if other lines become pending.
- R11: In control (0x48), writing 1 to bit 0 (IRQ) or bit 1 (FIQ) drives that output low on the same edge and re-arms it. Arbitration resumes on the next edge. Bit 2 is the global mask, which blocks both outputs while set; reads return only bit 2.
- R12: Bit 0 of 0x10 and bits [1:0] of 0x50 read back as written. Writing 1 to bit 1 of 0x10 performs a soft reset that restores the R1 state and clears these bits, the software bits, the active state and the level register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | NUM_BANKS*32 | Level-sensitive interrupt requests |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write enable, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
Two collisions are provoked on purpose.

The first is a single control write that re-arms IRQ and sets the global mask together. The output must drop on that edge and stay low while the mask holds. It must rise with the correct winner one edge after a later write clears the mask.

The second collision is a software-clear write while a hardware level is still high. The line must be judged from the remaining software bits ANDed with the level, so it goes inactive. In contrast, a line whose level falls while its software bit is set must stay pending.

Both are judged through the bank's pending registers and the two outputs, sampled half a cycle after each edge.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and register decode types for the interrupt
// controller. Assumes a 12-bit byte address and 32 lines per bank.
package intc_pkg;
    localparam int BANK_LINES = 32;
    localparam int LINE_W     = 5;
    localparam int ADDR_W     = 12;

    localparam logic [ADDR_W-1:0] A_REV    = 12'h000;
    localparam logic [ADDR_W-1:0] A_SYSCFG = 12'h010;
    localparam logic [ADDR_W-1:0] A_STATUS = 12'h014;
    localparam logic [ADDR_W-1:0] A_WIN_I  = 12'h040;
    localparam logic [ADDR_W-1:0] A_WIN_F  = 12'h044;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h048;
    localparam logic [ADDR_W-1:0] A_PROT   = 12'h04C;
    localparam logic [ADDR_W-1:0] A_IDLE   = 12'h050;
    localparam logic [ADDR_W-1:0] A_LINE0  = 12'h100;

    localparam logic [31:0] REV_VALUE = 32'h21;

    // Per-bank register slot, address bits [4:2] inside a bank window.
    typedef enum logic [2:0] {
        BR_LEVEL = 3'd0,
        BR_MASK  = 3'd1,
        BR_MCLR  = 3'd2,
        BR_MSET  = 3'd3,
        BR_SSET  = 3'd4,
        BR_SCLR  = 3'd5,
        BR_PIRQ  = 3'd6,
        BR_PFIQ  = 3'd7
    } bank_reg_e;
endpackage

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
// Module: one 32-line bank. Holds the sampled levels, mask, software bits,
// active state, steering bits and priorities. Assumes at most one register
// write per cycle; soft_rst acts like rst_n.
module intc_bank
    import intc_pkg::*;
#(
    parameter int PRIO_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         soft_rst,
    input  logic [BANK_LINES-1:0]        hw_in,
    input  logic                         reg_we,
    input  bank_reg_e                    reg_sel,
    input  logic [31:0]                  wdata,
    input  logic                         line_we,
    input  logic [LINE_W-1:0]            line_sel,
    output logic [BANK_LINES-1:0]        lvl_q,
    output logic [BANK_LINES-1:0]        mask_q,
    output logic [BANK_LINES-1:0]        swi_q,
    output logic [BANK_LINES-1:0]        act_q,
    output logic [BANK_LINES-1:0]        fiq_q,
    output logic [BANK_LINES*PRIO_W-1:0] prio_flat
);
    logic [BANK_LINES-1:0] rise, fall, mask_n, swi_n, act_n;
    logic [PRIO_W-1:0]     prio_q [BANK_LINES];

    // Next-state of mask, software bits and active state; writes take effect last.
    always_comb begin
        rise   = hw_in & ~lvl_q;
        fall   = ~hw_in & lvl_q;
        act_n  = (act_q | rise) & ~fall | (swi_q & fall);
        mask_n = mask_q;
        swi_n  = swi_q;
        if (reg_we) begin
            case (reg_sel)
                BR_MASK: mask_n = wdata;
                BR_MCLR: mask_n = mask_q & ~wdata;
                BR_MSET: mask_n = mask_q | wdata;
                BR_SSET: begin
                    swi_n = swi_q | wdata;
                    act_n = act_n | wdata;
                end
                BR_SCLR: begin
                    swi_n = swi_q & ~wdata;
                    act_n = swi_n & hw_in;
                end
                default: ;
            endcase
        end
    end

    // Bank state registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            lvl_q  <= '0;
            mask_q <= '1;
            swi_q  <= '0;
            act_q  <= '0;
        end else begin
            lvl_q  <= hw_in;
            mask_q <= mask_n;
            swi_q  <= swi_n;
            act_q  <= act_n;
        end
    end

    // Per-line priority and steering storage.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            fiq_q <= '0;
            for (int i = 0; i < BANK_LINES; i++) prio_q[i] <= '0;
        end else if (line_we) begin
            fiq_q[line_sel]  <= wdata[0];
            prio_q[line_sel] <= wdata[2 +: PRIO_W];
        end
    end

    for (genvar i = 0; i < BANK_LINES; i++) begin : g_flat
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end
endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
// Module: single-cycle compare tree over all lines. Lower priority value
// wins; on a tie the higher line number (right subtree) wins. Assumes
// NLINES >= 2.
module intc_arbiter #(
    parameter int NLINES = 64,
    parameter int PRIO_W = 6,
    parameter int IDX_W  = $clog2(NLINES)
) (
    input  logic [NLINES-1:0]        pend,
    input  logic [NLINES*PRIO_W-1:0] prio_flat,
    output logic                     win_vld,
    output logic [IDX_W-1:0]         win_idx
);
    localparam int LEAVES = 1 << $clog2(NLINES);
    localparam int NODES  = 2 * LEAVES - 1;

    logic              nv [NODES];
    logic [PRIO_W-1:0] np [NODES];
    logic [IDX_W-1:0]  ni [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NLINES) begin : g_real
            assign nv[LEAVES-1+i] = pend[i];
            assign np[LEAVES-1+i] = prio_flat[i*PRIO_W +: PRIO_W];
            assign ni[LEAVES-1+i] = IDX_W'(i);
        end else begin : g_pad
            assign nv[LEAVES-1+i] = 1'b0;
            assign np[LEAVES-1+i] = '0;
            assign ni[LEAVES-1+i] = '0;
        end
    end

    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        logic take_r;
        assign take_r = nv[2*k+2] && (!nv[2*k+1] || (np[2*k+2] <= np[2*k+1]));
        assign nv[k]  = nv[2*k+1] | nv[2*k+2];
        assign np[k]  = take_r ? np[2*k+2] : np[2*k+1];
        assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
    end

    assign win_vld = nv[0];
    assign win_idx = ni[0];
endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
// Module: top of the prioritised controller. Decodes the register bus, holds
// global control, runs one arbiter per output and the agreement handshake.
// Assumes NUM_BANKS <= 4 and word-aligned addresses.
module prio_intc
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int PRIO_W    = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_BANKS*32-1:0]      irq_lines,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic                         irq_o,
    output logic                         fiq_o
);
    localparam int NLINES = NUM_BANKS * BANK_LINES;
    localparam int IDX_W  = $clog2(NLINES);

    logic                     is_bank, bank_ok, line_hit, soft_rst;
    logic [1:0]               bank_sel;
    logic [ADDR_W-1:0]        line_off;
    logic [ADDR_W-3:0]        line_no;
    logic [BANK_LINES-1:0]    lvl_b [NUM_BANKS];
    logic [BANK_LINES-1:0]    mask_b [NUM_BANKS];
    logic [BANK_LINES-1:0]    swi_b [NUM_BANKS];
    logic [BANK_LINES-1:0]    act_b [NUM_BANKS];
    logic [BANK_LINES-1:0]    fiq_b [NUM_BANKS];
    logic [NLINES*PRIO_W-1:0] prio_all;
    logic [NLINES-1:0]        fiq_all;
    logic [NLINES-1:0]        pend [2];
    logic                     gmask_q, autoidle_q;
    logic [1:0]               idle_q;
    logic [1:0]               agree_wr, armed_q, out_q, win_vld;
    logic [IDX_W-1:0]         win_idx [2];
    logic [IDX_W-1:0]         sir_q [2];

    // Address decode for bank windows, line registers and soft reset.
    always_comb begin
        is_bank  = (bus_addr[ADDR_W-1:7] == 5'b00001);
        bank_sel = bus_addr[6:5];
        bank_ok  = is_bank && (int'(bank_sel) < NUM_BANKS);
        line_off = bus_addr - A_LINE0;
        line_no  = line_off[ADDR_W-1:2];
        line_hit = (bus_addr >= A_LINE0) && (int'(line_no) < NLINES);
        soft_rst = bus_we && (bus_addr == A_SYSCFG) && bus_wdata[1];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc_bank #(.PRIO_W(PRIO_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .hw_in    (irq_lines[b*BANK_LINES +: BANK_LINES]),
            .reg_we   (bus_we && bank_ok && (bank_sel == 2'(b))),
            .reg_sel  (bank_reg_e'(bus_addr[4:2])),
            .wdata    (bus_wdata),
            .line_we  (bus_we && line_hit && (line_no[ADDR_W-3:LINE_W] == (ADDR_W-2-LINE_W)'(b))),
            .line_sel (line_no[LINE_W-1:0]),
            .lvl_q    (lvl_b[b]),
            .mask_q   (mask_b[b]),
            .swi_q    (swi_b[b]),
            .act_q    (act_b[b]),
            .fiq_q    (fiq_b[b]),
            .prio_flat(prio_all[b*BANK_LINES*PRIO_W +: BANK_LINES*PRIO_W])
        );
        assign fiq_all[b*BANK_LINES +: BANK_LINES] = fiq_b[b];
        assign pend[0][b*BANK_LINES +: BANK_LINES] = act_b[b] & ~mask_b[b] & ~fiq_b[b];
        assign pend[1][b*BANK_LINES +: BANK_LINES] = act_b[b] & ~mask_b[b] & fiq_b[b];
    end

    // Global configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            gmask_q    <= 1'b0;
            autoidle_q <= 1'b0;
            idle_q     <= 2'b00;
        end else if (bus_we) begin
            if (bus_addr == A_CTRL)   gmask_q    <= bus_wdata[2];
            if (bus_addr == A_SYSCFG) autoidle_q <= bus_wdata[0];
            if (bus_addr == A_IDLE)   idle_q     <= bus_wdata[1:0];
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_out
        intc_arbiter #(.NLINES(NLINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
            .pend     (pend[k]),
            .prio_flat(prio_all),
            .win_vld  (win_vld[k]),
            .win_idx  (win_idx[k])
        );
        assign agree_wr[k] = bus_we && (bus_addr == A_CTRL) && bus_wdata[k];

        // Agreement handshake: latch winner once, hold until re-armed.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                armed_q[k] <= 1'b1;
                out_q[k]   <= 1'b0;
                sir_q[k]   <= '0;
            end else if (agree_wr[k]) begin
                armed_q[k] <= 1'b1;
                out_q[k]   <= 1'b0;
            end else if (armed_q[k] && win_vld[k] && !gmask_q) begin
                armed_q[k] <= 1'b0;
                out_q[k]   <= 1'b1;
                sir_q[k]   <= win_idx[k];
            end
        end
    end

    assign irq_o = out_q[0];
    assign fiq_o = out_q[1];

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_REV:    bus_rdata = REV_VALUE;
            A_SYSCFG: bus_rdata[0] = autoidle_q;
            A_STATUS: bus_rdata = 32'd1;
            A_WIN_I:  bus_rdata = 32'(sir_q[0]);
            A_WIN_F:  bus_rdata = 32'(sir_q[1]);
            A_CTRL:   bus_rdata[2] = gmask_q;
            A_IDLE:   bus_rdata[1:0] = idle_q;
            default: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (bank_ok && (bank_sel == 2'(b))) begin
                        case (bank_reg_e'(bus_addr[4:2]))
                            BR_LEVEL: bus_rdata = lvl_b[b];
                            BR_MASK:  bus_rdata = mask_b[b];
                            BR_SSET:  bus_rdata = swi_b[b];
                            BR_PIRQ:  bus_rdata = pend[0][b*BANK_LINES +: BANK_LINES];
                            BR_PFIQ:  bus_rdata = pend[1][b*BANK_LINES +: BANK_LINES];
                            default:  bus_rdata = '0;
                        endcase
                    end
                end
                for (int n = 0; n < NLINES; n++) begin
                    if (line_hit && (line_no == (ADDR_W-2)'(n))) begin
                        bus_rdata[2 +: PRIO_W] = prio_all[n*PRIO_W +: PRIO_W];
                        bus_rdata[0]           = fiq_all[n];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/intc_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for prio_intc, attached with bind. Assumes the
// sorted-winner width of the bound instance via IDX_W.
module intc_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             fiq_o,
    input logic             gmask,
    input logic [1:0]       armed,
    input logic [1:0]       pend_any,
    input logic [1:0]       agree_wr,
    input logic             soft_rst,
    input logic [IDX_W-1:0] sir_irq,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_rdata
);
    // R8: IRQ rises only after an armed, pending, unmasked cycle.
    a_r8_irq_rise_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(armed[0]) && $past(pend_any[0]) && !$past(gmask)));

    // R8: FIQ rises only after an armed, pending, unmasked cycle.
    a_r8_fiq_rise_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> ($past(armed[1]) && $past(pend_any[1]) && !$past(gmask)));

    // R10: an asserted IRQ stays up until re-armed or soft reset.
    a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !agree_wr[0] && !soft_rst) |=> irq_o);

    // R10: the latched IRQ winner does not move while IRQ stays high.
    a_r10_sir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o)) |-> $stable(sir_irq));

    // R11: re-arming drops the matching output on the same edge.
    a_r11_rearm_drop: assert property (@(posedge clk) disable iff (!rst_n)
        agree_wr[0] |=> !irq_o);

    // R12: soft reset clears both outputs.
    a_r12_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!irq_o && !fiq_o));

    // R2: revision register is constant.
    a_r2_revision: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'h000) |-> (bus_rdata == 32'h21));
endmodule

bind prio_intc intc_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .gmask    (gmask_q),
    .armed    (armed_q),
    .pend_any (win_vld),
    .agree_wr (agree_wr),
    .soft_rst (soft_rst),
    .sir_irq  (sir_q[0]),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/prio_intc_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard. Driver tasks queue expected values; a monitor pops and
// compares them 1 ns after each falling edge.
module prio_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] hw = '0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    prio_intc u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(hw), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    always #2 clk = ~clk;

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); addr = a;
        sbq.push_back('{0, e, tag});
    endtask

    task automatic chk_out(input int kind, input logic e, input string tag);
        sbq.push_back('{kind, {31'b0, e}, tag});
    endtask

    task automatic set_hw(input logic [63:0] v);
        @(negedge clk); hw = v;
    endtask

    // Monitor: compare queued expectations against the ports.
    initial forever begin
        @(negedge clk); #1;
        while (sbq.size() > 0) begin
            item_t       it;
            logic [31:0] got;
            it  = sbq.pop_front();
            got = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'b0, irq} : {31'b0, fiq};
            checks++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_out(1, 1'b0, "R1 irq low");
        chk_out(2, 1'b0, "R1 fiq low");
        rd(12'h084, 32'hFFFF_FFFF, "R1 bank0 mask");
        rd(12'h0A4, 32'hFFFF_FFFF, "R1 bank1 mask");
        rd(12'h040, 32'h0, "R1 irq winner");
        rd(12'h048, 32'h0, "R1 control");
        rd(12'h100, 32'h0, "R1 line reg");
        // R2 constants and ignored accesses
        rd(12'h000, 32'h21, "R2 revision");
        rd(12'h014, 32'h1, "R2 status");
        wr(12'h04C, 32'h1);
        rd(12'h04C, 32'h0, "R2 protection");
        wr(12'h000, 32'hFF);
        rd(12'h000, 32'h21, "R2 revision after write");
        rd(12'h200, 32'h0, "R2 line beyond count");
        rd(12'h0C4, 32'h0, "R2 bank beyond count");
        // R12 configuration bits
        wr(12'h010, 32'h1);
        rd(12'h010, 32'h1, "R12 autoidle");
        wr(12'h050, 32'h7);
        rd(12'h050, 32'h3, "R12 idle bits");
        // R7 line register
        wr(12'h114, 32'hFF);
        rd(12'h114, 32'hFD, "R7 line5 readback");
        wr(12'h114, 32'h0);
        // R3 level capture, R4 mask clear, R8 assertion
        set_hw(64'h8);
        rd(12'h080, 32'h8, "R3 level reg");
        rd(12'h098, 32'h0, "R6 masked pending");
        wr(12'h088, 32'h8);
        chk_out(1, 1'b0, "R8 irq not yet");
        rd(12'h098, 32'h8, "R6 pending irq");
        chk_out(1, 1'b1, "R8 irq raised");
        rd(12'h088, 32'h0, "R4 mask-clear reads 0");
        rd(12'h084, 32'hFFFF_FFF7, "R4 mask after clear");
        rd(12'h040, 32'd3, "R8 winner line3");
        // R10 hold against masking and input drop
        wr(12'h08C, 32'h8);
        chk_out(1, 1'b1, "R10 irq held after mask set");
        rd(12'h084, 32'hFFFF_FFFF, "R4 mask after set");
        set_hw(64'h0);
        rd(12'h040, 32'd3, "R10 winner held");
        chk_out(1, 1'b1, "R10 irq held after drop");
        // R9 tie and priority; R11 re-arm
        wr(12'h128, 32'h8);
        wr(12'h150, 32'h14);
        wr(12'h1A0, 32'h8);
        set_hw((64'h1 << 10) | (64'h1 << 20) | (64'h1 << 40));
        wr(12'h084, 32'h0);
        wr(12'h0A4, 32'h0);
        wr(12'h048, 32'h1);
        chk_out(1, 1'b0, "R11 rearm drops irq");
        rd(12'h040, 32'd40, "R9 tie highest line");
        chk_out(1, 1'b1, "R11 irq back");
        wr(12'h150, 32'h4);
        wr(12'h048, 32'h1);
        chk_out(1, 1'b0, "R11 rearm drops irq again");
        rd(12'h040, 32'd20, "R9 lowest priority wins");
        // R8 FIQ path, R6 pending split
        wr(12'h128, 32'h0D);
        chk_out(2, 1'b0, "R8 fiq not yet");
        rd(12'h044, 32'd10, "R8 fiq winner");
        chk_out(2, 1'b1, "R8 fiq raised");
        chk_out(1, 1'b1, "R10 irq unaffected");
        rd(12'h09C, 32'h400, "R6 pending fiq");
        rd(12'h098, 32'h0010_0000, "R6 pending irq bank0");
        rd(12'h0B8, 32'h100, "R6 pending irq bank1");
        // R11 global mask collides with re-arm
        wr(12'h048, 32'h5);
        chk_out(1, 1'b0, "R11 rearm with gmask");
        rd(12'h048, 32'h4, "R11 control readback");
        chk_out(1, 1'b0, "R11 gmask blocks");
        wr(12'h048, 32'h0);
        chk_out(1, 1'b0, "R11 one edge after unmask");
        rd(12'h040, 32'd20, "R11 winner after unmask");
        chk_out(1, 1'b1, "R11 irq after unmask");
        chk_out(2, 1'b1, "R10 fiq held");
        // R5 software bits, R3 fall with software bit
        wr(12'h0B0, 32'h1);
        rd(12'h0B0, 32'h1, "R5 swi readback");
        rd(12'h0B8, 32'h101, "R5 swi active");
        wr(12'h0B4, 32'h1);
        rd(12'h0B8, 32'h0, "R5 clear leaves swi AND level");
        rd(12'h0B4, 32'h0, "R5 clear reads 0");
        rd(12'h0A0, 32'h100, "R3 level bank1");
        wr(12'h090, 32'h0010_0000);
        set_hw(64'h1 << 40);
        rd(12'h098, 32'h0010_0000, "R3 swi keeps line");
        rd(12'h09C, 32'h0, "R3 fall without swi");
        rd(12'h090, 32'h0010_0000, "R5 swi bank0");
        // R12 soft reset
        wr(12'h010, 32'h3);
        chk_out(1, 1'b0, "R12 irq cleared");
        chk_out(2, 1'b0, "R12 fiq cleared");
        rd(12'h010, 32'h0, "R12 autoidle cleared");
        rd(12'h050, 32'h0, "R12 idle cleared");
        rd(12'h084, 32'hFFFF_FFFF, "R12 mask restored");
        rd(12'h128, 32'h0, "R12 line reg cleared");
        rd(12'h040, 32'h0, "R12 winner cleared");
        rd(12'h090, 32'h0, "R12 swi cleared");
        rd(12'h0A0, 32'h100, "R12 level resampled");
        rd(12'h048, 32'h0, "R12 control cleared");
        chk_out(1, 1'b0, "R12 irq stays low");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule